// File: doc/BRIEF.md
# DS3 Dual-Rail Line Decoder

This block sits between an external line interface and a DS3 framer. It takes two rails, one for positive pulses and one for negative pulses. Both are sampled on the recovered line clock, and the block turns them into one binary NRZ stream. That stream leaves on the same clock, so the framer downstream sees decoded data with a fixed delay.

Two configuration inputs set the line format. The first chooses single-rail NRZ, where only the positive rail carries data, or bipolar signalling. In bipolar signalling the second input chooses between two decoders. Plain alternate-mark-inversion decoding treats every pulse as a one. The B3ZS decoder also recognises the substitution codes that stand in for three consecutive zeros and restores those zeros. It does this through a short delay line, so the two bits before the code can still be cleared.

A bipolar violation is a pulse with the same polarity as the pulse before it. A bipolar violation that is not part of a substitution code raises a one-clock violation pulse, and so does a cycle with both rails high. Both events are reported aligned with the bit they belong to. A change of format empties the pipeline and forgets the polarity of the last pulse.

Top module: `ds3_line_decoder`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `nrz_out` and `lcv_out` are 0.
- R2: In single-rail mode (`cfg_bipolar`=0), the bit on `nrz_out` is the value `pos_in` had at a sampling edge.
- R3: In single-rail mode, `neg_in` has no effect and `lcv_out` stays 0.
- R4: Latency is constant. A value sampled at edge k appears on `nrz_out` and `lcv_out` right after edge k+2, in every mode.
- R5: In AMI mode (`cfg_bipolar`=1, `cfg_b3zs`=0), a cycle with exactly one rail high decodes as 1 and a cycle with neither rail high decodes as 0.
- R6: In bipolar modes, both rails high in one cycle decodes as 1 and raises `lcv_out` for that bit. Such a cycle never updates the stored pulse polarity.
- R7: In bipolar modes, a single-rail pulse on the same rail as the previous single-rail pulse is a violation. The first pulse after reset or after a format change is never a violation.
- R8: In AMI mode, every violation raises `lcv_out` for one clock, aligned with its bit.
- R9: In B3ZS mode (`cfg_bipolar`=1, `cfg_b3zs`=1), the pattern no-pulse, no-pulse, violation is decoded as three zeros, and `lcv_out` stays 0 for it.
- R10: In B3ZS mode, a pattern of three cycles is decoded as three zeros, with `lcv_out` 0, when it is a non-violating pulse, then no pulse, then a violation on the same rail as that pulse.
- R11: In B3ZS mode, a violation that fits neither substitution pattern keeps its decoded 1 and raises `lcv_out`.
- R12: A change of the effective format (single-rail, AMI, B3ZS) at an edge forces both outputs to 0 after that edge and discards that input. It also clears the stored history and the last polarity.
- R13: In single-rail mode, `cfg_b3zs` has no effect and toggling it is not a format change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock, the only timing source |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bipolar | input | 1 | 1 = bipolar signalling, 0 = single-rail NRZ |
| cfg_b3zs | input | 1 | In bipolar signalling: 1 = B3ZS decode, 0 = AMI decode |
| pos_in | input | 1 | Positive rail (the data input in single-rail mode) |
| neg_in | input | 1 | Negative rail |
| nrz_out | output | 1 | Decoded binary stream to the framer |
| lcv_out | output | 1 | One-clock line code violation pulse, aligned with nrz_out |

## Verification
The bench builds the block with its default parameters. The substitution group is three bits long, which gives a two-bit zero-restoring delay line and a two-entry pulse history. That exercises both B3ZS patterns, violations that sit next to a substitution, and a full encoded random stream with frequent zero runs. The streams are compared each cycle against a behavioural reference. Random rail noise in every format reaches the both-rails case, chains of repeated-polarity violations, and format switches in the middle of a group.

// File: rtl/ds3dec_pkg.sv
package ds3dec_pkg;

  // Length of one zero-substitution group on the line
  localparam int SUB_LEN = 3;
  // Bits that must stay erasable behind the current one
  localparam int HOLD = SUB_LEN - 1;

  typedef enum logic [1:0] {
    MODE_UNI  = 2'd0,
    MODE_AMI  = 2'd1,
    MODE_B3ZS = 2'd2
  } line_mode_t;

  function automatic line_mode_t pick_mode(input logic bipolar, input logic b3zs);
    if (!bipolar)  return MODE_UNI;
    else if (b3zs) return MODE_B3ZS;
    else           return MODE_AMI;
  endfunction

endpackage

// File: rtl/ds3dec_classify.sv
module ds3dec_classify
  import ds3dec_pkg::*;
#(
  parameter int HIST = HOLD
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  line_mode_t mode,
  input  logic       pos,
  input  logic       neg,
  output logic       bit_o,
  output logic       err_o,
  output logic       subst_o
);

  // hp[0] is the newest cycle; hv marks a pulse that was itself a violation
  logic [HIST-1:0] hp, hv;
  logic            have_last, last_pol;

  logic bip, pulse, both, single, bpv, gap, lead_ok;

  always_comb begin
    bip     = (mode != MODE_UNI);
    pulse   = bip & (pos | neg);
    both    = bip & pos & neg;
    single  = pulse & ~both;
    bpv     = single & have_last & (pos == last_pol);
    if (HIST > 1) gap = ~|hp[HIST-2:0];
    else          gap = 1'b1;
    lead_ok = ~hp[HIST-1] | ~hv[HIST-1];
    subst_o = (mode == MODE_B3ZS) & bpv & gap & lead_ok;
    err_o   = both | (bpv & ~subst_o);
    bit_o   = bip ? pulse : pos;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hp        <= '0;
      hv        <= '0;
      have_last <= 1'b0;
      last_pol  <= 1'b0;
    end else begin
      if (HIST > 1) begin
        hp <= {hp[HIST-2:0], pulse};
        hv <= {hv[HIST-2:0], both | bpv};
      end else begin
        hp <= pulse;
        hv <= both | bpv;
      end
      if (single) begin
        have_last <= 1'b1;
        last_pol  <= pos;
      end
    end
  end

  // R6: a both-rails cycle can never close a substitution group
  a_r6_both_not_subst: assert property (@(posedge clk) disable iff (rst)
    (pos && neg) |-> !subst_o);

  // R7: the first pulse after a flush is never taken as a violation
  a_r7_first_pulse_clean: assert property (@(posedge clk) disable iff (rst)
    flush |=> !(subst_o || (err_o && !(pos && neg))));

endmodule

// File: rtl/ds3dec_delay.sv
module ds3dec_delay
  import ds3dec_pkg::*;
#(
  parameter int DEPTH = HOLD
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic bit_i,
  input  logic flag_i,
  input  logic zero_i,
  output logic nrz_o,
  output logic lcv_o
);

  logic [DEPTH-1:0] bq, fq;
  logic [DEPTH-1:0] bq_next, fq_next;

  generate
    if (DEPTH > 1) begin : g_multi
      assign bq_next = {bq[DEPTH-2:0], bit_i};
      assign fq_next = {fq[DEPTH-2:0], flag_i};
    end else begin : g_single
      assign bq_next = bit_i;
      assign fq_next = flag_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      bq    <= '0;
      fq    <= '0;
      nrz_o <= 1'b0;
      lcv_o <= 1'b0;
    end else begin
      fq    <= fq_next;
      lcv_o <= fq[DEPTH-1];
      if (zero_i) begin
        bq    <= '0;
        nrz_o <= 1'b0;
      end else begin
        bq    <= bq_next;
        nrz_o <= bq[DEPTH-1];
      end
    end
  end

  // R9: a recognised group leaves nothing but zeros behind it
  a_r9_group_erased: assert property (@(posedge clk) disable iff (rst)
    (zero_i && !flush) |=> (nrz_o == 1'b0) && (bq == '0));

endmodule

// File: rtl/ds3_line_decoder.sv
module ds3_line_decoder
  import ds3dec_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cfg_bipolar,
  input  logic cfg_b3zs,
  input  logic pos_in,
  input  logic neg_in,
  output logic nrz_out,
  output logic lcv_out
);

  line_mode_t cur_mode, mode_q;
  logic       flush;
  logic       dec_bit, dec_err, dec_sub;

  assign cur_mode = pick_mode(cfg_bipolar, cfg_b3zs);
  assign flush    = (cur_mode != mode_q);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= cur_mode;
    else     mode_q <= cur_mode;
  end

  ds3dec_classify #(.HIST(HOLD)) u_cls (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .mode    (mode_q),
    .pos     (pos_in),
    .neg     (neg_in),
    .bit_o   (dec_bit),
    .err_o   (dec_err),
    .subst_o (dec_sub)
  );

  ds3dec_delay #(.DEPTH(HOLD)) u_dly (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .bit_i  (dec_bit),
    .flag_i (dec_err),
    .zero_i (dec_sub),
    .nrz_o  (nrz_out),
    .lcv_o  (lcv_out)
  );

  // Edges since the last reset or flush, saturating; used only by the checks
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst || flush)   age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2, R4: single-rail data emerges three samples later
  a_r2_uni_data: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && mode_q == MODE_UNI) |-> nrz_out == $past(pos_in, 3));

  // R5, R4: AMI data is the OR of the rails three samples later
  a_r5_ami_data: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && mode_q == MODE_AMI) |-> nrz_out == $past(pos_in | neg_in, 3));

  // R3: no violation is ever reported in single-rail mode
  a_r3_uni_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_UNI) |-> !lcv_out);

  // R12: a format change clears both outputs
  a_r12_flush_zero: assert property (@(posedge clk) disable iff (rst)
    flush |=> !nrz_out && !lcv_out);

endmodule

// File: tb/sim_ds3_line_decoder.sv
module sim_ds3_line_decoder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_bipolar = 1'b0, cfg_b3zs = 1'b0, pos_in = 1'b0, neg_in = 1'b0;
  logic nrz_out, lcv_out;

  always #10 clk = ~clk;

  ds3_line_decoder u0 (
    .clk(clk), .rst(rst), .cfg_bipolar(cfg_bipolar), .cfg_b3zs(cfg_b3zs),
    .pos_in(pos_in), .neg_in(neg_in), .nrz_out(nrz_out), .lcv_out(lcv_out)
  );

  int vectors = 0;
  int miscompares = 0;

  // Reference model state (behavioural)
  int mm;
  int have_last, last_pol;
  int pulse_q[$];
  int viol_q[$];
  int bit_pipe[$];
  int flag_pipe[$];
  int exp_n, exp_l;

  function automatic int mode_of(input logic bi, input logic b3);
    if (!bi) return 0;
    return b3 ? 2 : 1;
  endfunction

  function automatic void mclear();
    have_last = 0; last_pol = 0;
    pulse_q = '{0, 0}; viol_q = '{0, 0};
    bit_pipe = '{0, 0, 0}; flag_pipe = '{0, 0, 0};
    exp_n = 0; exp_l = 0;
  endfunction

  function automatic void model(input logic p, input logic n, input logic bi, input logic b3);
    int nm, b, e, s, pulse, both, single, v;
    nm = mode_of(bi, b3);
    if (nm != mm) begin
      mm = nm;
      mclear();
      return;
    end
    s = 0; e = 0;
    if (mm == 0) begin
      b = p;
      pulse = 0; v = 0; both = 0;
    end else begin
      pulse  = (p || n) ? 1 : 0;
      both   = (p && n) ? 1 : 0;
      single = pulse && !both;
      v = (single && have_last && (last_pol == int'(p))) ? 1 : 0;
      // pulse_q[0] = previous cycle, pulse_q[1] = two cycles back
      if (mm == 2 && v && pulse_q[0] == 0 && (pulse_q[1] == 0 || viol_q[1] == 0)) s = 1;
      e = (both || (v && !s)) ? 1 : 0;
      b = pulse;
      if (single) begin have_last = 1; last_pol = p; end
    end
    pulse_q.push_front(pulse); void'(pulse_q.pop_back());
    viol_q.push_front((both || v) ? 1 : 0); void'(viol_q.pop_back());
    bit_pipe.push_front(b); void'(bit_pipe.pop_back());
    flag_pipe.push_front(e); void'(flag_pipe.pop_back());
    if (s) bit_pipe = '{0, 0, 0};
    exp_n = bit_pipe[2];
    exp_l = flag_pipe[2];
  endfunction

  task automatic check(input string tag);
    vectors++;
    if (nrz_out !== exp_n[0] || lcv_out !== exp_l[0]) begin
      miscompares++;
      $display("FAIL %s: nrz/lcv actual %b/%b expected %0d/%0d at %0t",
               tag, nrz_out, lcv_out, exp_n, exp_l, $time);
    end
  endtask

  task automatic step(input logic p, input logic n, input logic bi, input logic b3,
                      input string tag);
    pos_in = p; neg_in = n; cfg_bipolar = bi; cfg_b3zs = b3;
    model(p, n, bi, b3);
    @(posedge clk); #2;
    check(tag);
  endtask

  // sym: 0 none, 1 positive rail, -1 negative rail
  task automatic put(input int sym, input logic bi, input logic b3, input string tag);
    step(sym == 1, sym == -1, bi, b3, tag);
  endtask

  task automatic flushz(input logic bi, input logic b3, input string tag);
    for (int i = 0; i < 4; i++) put(0, bi, b3, tag);
  endtask

  int sym_arr[400];
  logic data_arr[400];

  task automatic b3zs_stream(input int len);
    int lastp, cnt, zrun;
    lastp = -1; cnt = 0; zrun = 0;
    for (int i = 0; i < len; i++) begin
      data_arr[i] = (i == 0) ? 1'b1 : (($urandom % 3) == 0);
      if (data_arr[i]) begin
        lastp = -lastp; sym_arr[i] = lastp; cnt++; zrun = 0;
      end else begin
        sym_arr[i] = 0; zrun++;
        if (zrun == 3) begin
          if (cnt % 2 == 1) begin
            sym_arr[i] = lastp;
          end else begin
            lastp = -lastp; sym_arr[i-2] = lastp; sym_arr[i] = lastp;
          end
          cnt = 0; zrun = 0;
        end
      end
    end
    for (int i = 0; i < len; i++) put(sym_arr[i], 1'b1, 1'b1, "R10");
  endtask

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    mm = 0;
    mclear();
    repeat (3) @(posedge clk);
    #2;
    check("R1");
    rst = 1'b0;

    // R2, R3, R4: single-rail, random negative rail, latency
    for (int i = 0; i < 200; i++)
      step($urandom % 2, $urandom % 2, 1'b0, 1'b0, "R2");
    // R13: b3zs select toggling in single-rail mode
    for (int i = 0; i < 60; i++)
      step($urandom % 2, $urandom % 2, 1'b0, $urandom % 2, "R13");

    // R12: switch to AMI, then R5/R7/R8 directed
    put(1, 1'b1, 1'b0, "R12");
    put(1, 1'b1, 1'b0, "R7");
    put(-1, 1'b1, 1'b0, "R5");
    put(0, 1'b1, 1'b0, "R5");
    put(-1, 1'b1, 1'b0, "R8");
    put(-1, 1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, 1'b1, 1'b0, "R6");
    put(1, 1'b1, 1'b0, "R6");
    put(0, 1'b1, 1'b0, "R8");
    put(0, 1'b1, 1'b0, "R8");
    put(0, 1'b1, 1'b0, "R4");
    for (int i = 0; i < 300; i++)
      step($urandom % 2, $urandom % 2, 1'b1, 1'b0, "R8");

    // R12: switch to B3ZS, last polarity forgotten
    put(1, 1'b1, 1'b1, "R12");
    put(1, 1'b1, 1'b1, "R7");
    put(0, 1'b1, 1'b1, "R9");
    put(0, 1'b1, 1'b1, "R9");
    put(1, 1'b1, 1'b1, "R9");
    put(0, 1'b1, 1'b1, "R9");
    put(-1, 1'b1, 1'b1, "R10");
    put(0, 1'b1, 1'b1, "R10");
    put(-1, 1'b1, 1'b1, "R10");
    put(-1, 1'b1, 1'b1, "R11");
    put(1, 1'b1, 1'b1, "R11");
    put(0, 1'b1, 1'b1, "R11");
    put(1, 1'b1, 1'b1, "R11");
    step(1'b1, 1'b1, 1'b1, 1'b1, "R6");
    put(0, 1'b1, 1'b1, "R6");
    put(1, 1'b1, 1'b1, "R6");
    flushz(1'b1, 1'b1, "R11");
    for (int i = 0; i < 300; i++)
      step($urandom % 2, $urandom % 2, 1'b1, 1'b1, "R11");

    // Encoded B3ZS stream with a fresh start
    put(0, 1'b0, 1'b0, "R12");
    put(0, 1'b1, 1'b1, "R12");
    b3zs_stream(400);
    flushz(1'b1, 1'b1, "R10");

    // Mixed format switching
    for (int i = 0; i < 500; i++)
      step($urandom % 2, $urandom % 2, ($urandom % 4) != 0, ($urandom % 8) != 0, "R12");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule